// File: doc/BRIEF.md
# Dual-Clock FIFO with Mailbox Bypass

This block carries 36-bit words in one direction between two independently clocked ports. Port A pushes words into a 64-entry queue and port B pops them in arrival order. The two clocks may be unrelated or may be one and the same net. Each side sees only flags that are computed from registers in its own clock domain. The write side sees full and almost-full. The read side sees empty and almost-empty. A bidirectional link is built from two instances of the block, one for each direction.

Next to the queue there is a single-word mailbox. A word written through it skips the queue and waits for port B, and a flag on each side shows that the mailbox is occupied. Each 36-bit word is treated as four 9-bit lanes. Bit 8, 17, 26 or 35 is the parity bit of its lane. Port A checks parity on its input bus without altering the data. Port B can replace the parity bits of the words it delivers. A single sense input selects odd or even parity for both checking and generation.

The almost-full and almost-empty thresholds come from a 2-bit strap that is sampled while reset is held. After reset the strap is ignored.

Top module: `mbf_dual_clock_fifo`

## Requirements
- R1: Words accepted on port A (cs_a_i=1, wr_a_i=1, en_a_i=1, mb_a_i=0, full_o=0 at the clk_a edge) leave on data_b_o in the same order, one per accepted read (cs_b_i=1, rd_b_i=1, en_b_i=1, mb_b_i=0, empty_o=0 at the clk_b edge), and are unchanged when gen_par_b_i=0; a read loads data_b_o at that clk_b edge.
- R2: full_o is high when 64 words are stored as seen from clk_a; a write attempted while full_o is high is dropped.
- R3: empty_o is high when no word is stored as seen from clk_b; a read attempted while empty_o is high leaves data_b_o unchanged and pops nothing.
- R4: afull_o is high when the number of free entries seen from clk_a is at most the selected offset.
- R5: aempty_o is high when the number of stored words seen from clk_b is at most the selected offset.
- R6: fs_sel_i is sampled only while rst_ni is low: code 01 selects offset 16, code 10 selects 64, and codes 00 and 11 select 8. Changes to fs_sel_i after reset have no effect.
- R7: A mailbox write (cs_a_i, wr_a_i, en_a_i, mb_a_i all 1) stores the word and raises mbox_full_a_o after that clk_a edge. mbox_full_b_o rises a few clk_b cycles later. A mailbox read (cs_b_i, rd_b_i, en_b_i, mb_b_i all 1) puts the word on data_b_o and clears mbox_full_b_o at that edge, and mbox_full_a_o clears a few clk_a cycles later. Mailbox traffic does not touch the queue.
- R8: A mailbox write while mbox_full_a_o is high is ignored, and the stored word is kept.
- R9: par_err_a_o is high whenever any 9-bit lane of data_a_i has an XOR that differs from odd_i (odd_i=1 demands an odd count of ones). Words with bad parity are still stored unchanged.
- R10: With gen_par_b_i=1 at a read, bits 8, 17, 26 and 35 of data_b_o are set so that each lane meets the odd_i sense. The other 32 bits pass through.
- R11: With a shared clock, a write and a read on the same edge both succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Write-side clock |
| clk_b_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_sel_i | input | 2 | Offset strap, sampled during reset |
| odd_i | input | 1 | Parity sense, 1 = odd |
| cs_a_i | input | 1 | Port A select |
| wr_a_i | input | 1 | Port A direction, 1 = write |
| en_a_i | input | 1 | Port A enable |
| mb_a_i | input | 1 | Port A targets the mailbox |
| data_a_i | input | 36 | Port A write data |
| par_err_a_o | output | 1 | Port A lane parity error |
| full_o | output | 1 | Queue full (clk_a) |
| afull_o | output | 1 | Queue almost full (clk_a) |
| mbox_full_a_o | output | 1 | Mailbox occupied (clk_a) |
| cs_b_i | input | 1 | Port B select |
| rd_b_i | input | 1 | Port B direction, 1 = read |
| en_b_i | input | 1 | Port B enable |
| mb_b_i | input | 1 | Port B targets the mailbox |
| gen_par_b_i | input | 1 | Regenerate parity bits on read |
| data_b_o | output | 36 | Port B registered read data |
| empty_o | output | 1 | Queue empty (clk_b) |
| aempty_o | output | 1 | Queue almost empty (clk_b) |
| mbox_full_b_o | output | 1 | Mailbox occupied (clk_b) |

## Verification
The collision of interest is a queue write on port A and a queue pop on port B landing on the same edge, while the stored count sits near empty. The bench provokes it by tying both ports to one clock and driving random enables. Acceptance of each side is judged from the flags that the design presents before the edge. A directed case stores exactly one word and then fires a write and a read together. It passes when the popped value matches the reference queue and empty_o stays low once the flags have settled.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int unsigned LANE_W  = 9;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = LANE_W * LANES;
  localparam int unsigned OFS_DEF = 8;
  localparam int unsigned OFS_MID = 16;
  localparam int unsigned OFS_MAX = 64;

  function automatic int unsigned fs_offset(input logic [1:0] fs);
    case (fs)
      2'b01:   return OFS_MID;
      2'b10:   return OFS_MAX;
      default: return OFS_DEF;
    endcase
  endfunction
endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mbf_par_chk.sv
module mbf_par_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    odd_i,
  output logic                    err_o
);
  logic [LANES-1:0] lane_err;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned TOP = l * LANE_W + LANE_W - 1;
    assign lane_err[l] = (^data_i[TOP -: LANE_W]) != odd_i;
  end

  assign err_o = |lane_err;
endmodule

// File: rtl/mbf_par_gen.sv
module mbf_par_gen #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    odd_i,
  input  logic                    en_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned TOP = l * LANE_W + LANE_W - 1;
    assign data_o[TOP-1 -: LANE_W-1] = data_i[TOP-1 -: LANE_W-1];
    // MSB of each lane is its parity bit
    assign data_o[TOP] = en_i ? (odd_i ^ (^data_i[TOP-1 -: LANE_W-1])) : data_i[TOP];
  end
endmodule

// File: rtl/mbf_mailbox.sv
module mbf_mailbox #(
  parameter int unsigned W = 36
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         full_a_o,
  output logic         full_b_o
);
  logic         tog_a_q, tog_b_q, tog_a_sync, tog_b_sync;
  logic [W-1:0] data_q;

  mbf_sync #(.W(1)) u_sync_ab (.clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(tog_a_q), .q_o(tog_a_sync));
  mbf_sync #(.W(1)) u_sync_ba (.clk_i(clk_a_i), .rst_ni(rst_ni), .d_i(tog_b_q), .q_o(tog_b_sync));

  assign full_a_o = tog_a_q ^ tog_b_sync;
  assign full_b_o = tog_a_sync ^ tog_b_q;

  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_a_q <= 1'b0;
      data_q  <= '0;
    end else if (wr_i && !full_a_o) begin
      tog_a_q <= ~tog_a_q;
      data_q  <= data_i;
    end
  end

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni)                tog_b_q <= 1'b0;
    else if (rd_i && full_b_o)  tog_b_q <= ~tog_b_q;
  end

  // held stable while the flag is set, so read unsynchronized
  assign data_o = data_q;
endmodule

// File: rtl/mbf_dual_clock_fifo.sv
module mbf_dual_clock_fifo
  import mbf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic [1:0]        fs_sel_i,
  input  logic              odd_i,
  input  logic              cs_a_i,
  input  logic              wr_a_i,
  input  logic              en_a_i,
  input  logic              mb_a_i,
  input  logic [WORD_W-1:0] data_a_i,
  output logic              par_err_a_o,
  output logic              full_o,
  output logic              afull_o,
  output logic              mbox_full_a_o,
  input  logic              cs_b_i,
  input  logic              rd_b_i,
  input  logic              en_b_i,
  input  logic              mb_b_i,
  input  logic              gen_par_b_i,
  output logic [WORD_W-1:0] data_b_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              mbox_full_b_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [CW-1:0] rgray_sync, wgray_sync, rbin_a, wbin_b, cnt_a, cnt_b;
  logic [CW-1:0] afull_ofs_q, aempty_ofs_q;
  logic [CW-1:0] wbin_nxt, rbin_nxt;
  logic          wr_req, rd_req, mb_wr, mb_rd, fifo_we, fifo_re;
  logic [WORD_W-1:0] mbox_data, rd_raw, rd_gen, data_q;

  // port decode
  assign wr_req  = cs_a_i & wr_a_i & en_a_i & ~mb_a_i;
  assign mb_wr   = cs_a_i & wr_a_i & en_a_i &  mb_a_i;
  assign rd_req  = cs_b_i & rd_b_i & en_b_i & ~mb_b_i;
  assign mb_rd   = cs_b_i & rd_b_i & en_b_i &  mb_b_i;
  assign fifo_we = wr_req & ~full_o;
  assign fifo_re = rd_req & ~empty_o;

  // write domain
  mbf_sync #(.W(CW)) u_sync_r (.clk_i(clk_a_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_sync));
  assign rbin_a   = g2b(rgray_sync);
  assign cnt_a    = wbin_q - rbin_a;
  assign full_o   = cnt_a == DEPTH_C;
  assign afull_o  = (DEPTH_C - cnt_a) <= afull_ofs_q;
  assign wbin_nxt = wbin_q + CW'(1);

  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q      <= '0;
      wgray_q     <= '0;
      afull_ofs_q <= CW'(fs_offset(fs_sel_i));  // strap latched while reset held
    end else if (fifo_we) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  always_ff @(posedge clk_a_i) begin
    if (fifo_we) mem[wbin_q[AW-1:0]] <= data_a_i;
  end

  mbf_par_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk_a (
    .data_i(data_a_i), .odd_i(odd_i), .err_o(par_err_a_o)
  );

  // read domain
  mbf_sync #(.W(CW)) u_sync_w (.clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_sync));
  assign wbin_b   = g2b(wgray_sync);
  assign cnt_b    = wbin_b - rbin_q;
  assign empty_o  = cnt_b == '0;
  assign aempty_o = cnt_b <= aempty_ofs_q;
  assign rbin_nxt = rbin_q + CW'(1);

  assign rd_raw = mb_rd ? mbox_data : mem[rbin_q[AW-1:0]];

  mbf_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen_b (
    .data_i(rd_raw), .odd_i(odd_i), .en_i(gen_par_b_i), .data_o(rd_gen)
  );

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q       <= '0;
      rgray_q      <= '0;
      data_q       <= '0;
      aempty_ofs_q <= CW'(fs_offset(fs_sel_i));
    end else begin
      if (fifo_re) begin
        rbin_q  <= rbin_nxt;
        rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      end
      if (fifo_re || mb_rd) data_q <= rd_gen;
    end
  end

  assign data_b_o = data_q;

  mbf_mailbox #(.W(WORD_W)) u_mbox (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .rst_ni  (rst_ni),
    .wr_i    (mb_wr),
    .data_i  (data_a_i),
    .rd_i    (mb_rd),
    .data_o  (mbox_data),
    .full_a_o(mbox_full_a_o),
    .full_b_o(mbox_full_b_o)
  );
endmodule

// File: rtl/mbf_dual_clock_fifo_chk.sv
module mbf_dual_clock_fifo_chk #(
  parameter int unsigned CW = 7,
  parameter int unsigned W  = 36,
  parameter int unsigned DEPTH = 64
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] wgray_q,
  input logic [CW-1:0] wbin_q,
  input logic [CW-1:0] rbin_q,
  input logic          wr_req,
  input logic          rd_req,
  input logic          mb_wr,
  input logic          full_o,
  input logic          afull_o,
  input logic          empty_o,
  input logic          aempty_o,
  input logic          mbox_full_a_o,
  input logic [W-1:0]  mbox_data
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    cnt_a <= CW'(DEPTH));  // R2
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (full_o && wr_req) |=> $stable(wbin_q));  // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    cnt_b <= CW'(DEPTH));  // R3
  AST_EMPTY_DROPS_READ: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (empty_o && rd_req) |=> $stable(rbin_q));  // R3
  AST_AFULL_COVERS_FULL: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    full_o |-> afull_o);  // R4
  AST_AEMPTY_COVERS_EMPTY: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);  // R5
  AST_MAIL_KEPT: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mbox_full_a_o && mb_wr) |=> $stable(mbox_data));  // R8
  AST_GRAY_ONE_STEP: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);  // R1
endmodule

bind mbf_dual_clock_fifo mbf_dual_clock_fifo_chk #(
  .CW(CW), .W(mbf_pkg::WORD_W), .DEPTH(DEPTH)
) u_chk (
  .clk_a_i      (clk_a_i),
  .clk_b_i      (clk_b_i),
  .rst_ni       (rst_ni),
  .cnt_a        (cnt_a),
  .cnt_b        (cnt_b),
  .wgray_q      (wgray_q),
  .wbin_q       (wbin_q),
  .rbin_q       (rbin_q),
  .wr_req       (wr_req),
  .rd_req       (rd_req),
  .mb_wr        (mb_wr),
  .full_o       (full_o),
  .afull_o      (afull_o),
  .empty_o      (empty_o),
  .aempty_o     (aempty_o),
  .mbox_full_a_o(mbox_full_a_o),
  .mbox_data    (mbox_data)
);

// File: tb/tb_mbf_dual_clock_fifo.sv
module tb_mbf_dual_clock_fifo;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int SEED         = 20240611;

  logic clk_a = 1'b0, clk_bf = 1'b0, same_clk = 1'b0, clk_b;
  logic rst_ni = 1'b0;
  logic [1:0] fs_sel = 2'b01;
  logic odd = 1'b1;
  logic cs_a = 0, wr_a = 0, en_a = 0, mb_a = 0;
  logic [35:0] data_a = '0;
  logic par_err_a, full, afull, mfull_a;
  logic cs_b = 0, rd_b = 0, en_b = 0, mb_b = 0, gen_b = 0;
  logic [35:0] data_b;
  logic empty, aempty, mfull_b;

  int n_chk = 0, n_err = 0;
  logic [35:0] q [$];

  always #(CLK_PERIOD/2)   clk_a  = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_bf = ~clk_bf;
  assign clk_b = same_clk ? clk_a : clk_bf;

  mbf_dual_clock_fifo dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni), .fs_sel_i(fs_sel), .odd_i(odd),
    .cs_a_i(cs_a), .wr_a_i(wr_a), .en_a_i(en_a), .mb_a_i(mb_a), .data_a_i(data_a),
    .par_err_a_o(par_err_a), .full_o(full), .afull_o(afull), .mbox_full_a_o(mfull_a),
    .cs_b_i(cs_b), .rd_b_i(rd_b), .en_b_i(en_b), .mb_b_i(mb_b), .gen_par_b_i(gen_b),
    .data_b_o(data_b), .empty_o(empty), .aempty_o(aempty), .mbox_full_b_o(mfull_b)
  );

  function automatic logic [35:0] make_par(input logic [35:0] w, input logic o);
    logic [35:0] r = w;
    for (int l = 0; l < 4; l++) r[l*9+8] = o ^ (^w[l*9 +: 8]);
    return r;
  endfunction

  function automatic logic [35:0] rnd_word();
    return 36'({$urandom(), $urandom()});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] fs);
    rst_ni = 1'b0;
    fs_sel = fs;
    {cs_a, wr_a, en_a, mb_a, cs_b, rd_b, en_b, mb_b, gen_b} = '0;
    repeat (3) @(posedge clk_a);
    repeat (3) @(posedge clk_b);
    @(negedge clk_a);
    rst_ni = 1'b1;
    q.delete();
  endtask

  task automatic push(input logic [35:0] w, input logic mb);
    @(negedge clk_a);
    cs_a = 1; wr_a = 1; en_a = 1; mb_a = mb; data_a = w;
    @(negedge clk_a);
    en_a = 0; mb_a = 0;
  endtask

  task automatic pop(input logic mb, input logic gen, output logic [35:0] w);
    @(negedge clk_b);
    cs_b = 1; rd_b = 1; en_b = 1; mb_b = mb; gen_b = gen;
    @(negedge clk_b);
    en_b = 0; mb_b = 0; gen_b = 0;
    w = data_b;
  endtask

  task automatic settle_a();
    repeat (6) @(posedge clk_b);
    repeat (6) @(posedge clk_a);
    @(negedge clk_a);
  endtask

  task automatic settle_b();
    repeat (6) @(posedge clk_a);
    repeat (6) @(posedge clk_b);
    @(negedge clk_b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [35:0] w, got, exp, last;
    int sim;
    bit rd_pend, wv, rv, wacc;
    void'($urandom(SEED));

    // reset state, offset 16; strap changed afterwards (R6)
    do_reset(2'b01);
    fs_sel = 2'b10;
    @(negedge clk_a);
    chk(full === 1'b0 && afull === 1'b0 && mfull_a === 1'b0, "R2 reset", {33'd0, full, afull, mfull_a}, '0);
    @(negedge clk_b);
    chk(empty === 1'b1 && aempty === 1'b1 && mfull_b === 1'b0, "R3 reset", {33'd0, empty, aempty, mfull_b}, 36'h6);
    chk(data_b === '0, "R1 reset data", data_b, '0);

    // thresholds with offset 16
    for (int i = 0; i < 16; i++) begin w = make_par(rnd_word(), odd); push(w, 0); q.push_back(w); end
    settle_b();
    chk(empty === 1'b0 && aempty === 1'b1, "R5 16 stored", {34'd0, empty, aempty}, 36'h1);
    w = make_par(rnd_word(), odd); push(w, 0); q.push_back(w);
    settle_b();
    chk(aempty === 1'b0, "R5 17 stored", {35'd0, aempty}, '0);
    for (int i = 17; i < 47; i++) begin w = make_par(rnd_word(), odd); push(w, 0); q.push_back(w); end
    settle_a();
    chk(afull === 1'b0, "R4/R6 47 stored", {35'd0, afull}, '0);
    w = make_par(rnd_word(), odd); push(w, 0); q.push_back(w);
    settle_a();
    chk(afull === 1'b1 && full === 1'b0, "R4 48 stored", {34'd0, afull, full}, 36'h2);
    for (int i = 48; i < 64; i++) begin w = make_par(rnd_word(), odd); push(w, 0); q.push_back(w); end
    settle_a();
    chk(full === 1'b1, "R2 64 stored", {35'd0, full}, 36'h1);
    push(36'hF_0F0F_0F0F, 0);  // dropped
    settle_b();
    for (int i = 0; i < 64; i++) begin
      pop(0, 0, got);
      exp = q.pop_front();
      chk(got === exp, "R1 order", got, exp);
      last = got;
    end
    settle_b();
    chk(empty === 1'b1, "R2 overflow dropped", {35'd0, empty}, 36'h1);
    pop(0, 0, got);
    chk(got === last, "R3 read on empty", got, last);

    // mailbox
    push(36'hA_5555_AAAA, 1);
    chk(mfull_a === 1'b1, "R7 flag A", {35'd0, mfull_a}, 36'h1);
    push(36'h1_2345_6789, 1);  // ignored
    settle_b();
    chk(mfull_b === 1'b1 && empty === 1'b1, "R7 flag B", {34'd0, mfull_b, empty}, 36'h3);
    pop(1, 0, got);
    chk(got === 36'hA_5555_AAAA, "R8 first mail kept", got, 36'hA_5555_AAAA);
    chk(mfull_b === 1'b0, "R7 clear B", {35'd0, mfull_b}, '0);
    settle_a();
    chk(mfull_a === 1'b0, "R7 clear A", {35'd0, mfull_a}, '0);

    // parity check (combinational)
    @(negedge clk_a);
    w = make_par(36'h3_1234_5678, 1'b1);
    odd = 1'b1; data_a = w; #1;
    chk(par_err_a === 1'b0, "R9 good odd", {35'd0, par_err_a}, '0);
    data_a = w ^ 36'h0_0010_0000; #1;
    chk(par_err_a === 1'b1, "R9 flipped bit", {35'd0, par_err_a}, 36'h1);
    odd = 1'b0; data_a = w; #1;
    chk(par_err_a === 1'b1, "R9 sense even", {35'd0, par_err_a}, 36'h1);
    odd = 1'b1;
    w = make_par(rnd_word(), 1'b1) ^ 36'h8_0000_0000;
    push(w, 0);
    settle_b();
    pop(0, 0, got);
    chk(got === w, "R9 data unchanged", got, w);
    w = rnd_word();
    push(w, 0);
    settle_b();
    pop(0, 1, got);
    exp = make_par(w, 1'b1);
    chk(got === exp, "R10 gen odd", got, exp);
    odd = 1'b0;
    w = rnd_word();
    push(w, 0);
    settle_b();
    pop(0, 1, got);
    exp = make_par(w, 1'b0);
    chk(got === exp, "R10 gen even", got, exp);
    odd = 1'b1;

    // offset codes 11 and 10
    do_reset(2'b11);
    for (int i = 0; i < 8; i++) push(rnd_word(), 0);
    settle_b();
    chk(aempty === 1'b1, "R6 code 11 at 8", {35'd0, aempty}, 36'h1);
    push(rnd_word(), 0);
    settle_b();
    chk(aempty === 1'b0, "R6 code 11 at 9", {35'd0, aempty}, '0);
    do_reset(2'b10);
    @(negedge clk_a);
    chk(afull === 1'b1, "R6 code 10 afull", {35'd0, afull}, 36'h1);
    for (int i = 0; i < 40; i++) push(rnd_word(), 0);
    settle_b();
    chk(aempty === 1'b1 && empty === 1'b0, "R6 code 10 aempty", {34'd0, aempty, empty}, 36'h2);

    // shared clock: directed collision then random
    same_clk = 1'b1;
    do_reset(2'b01);
    w = make_par(rnd_word(), odd); push(w, 0);
    settle_a();
    exp = make_par(rnd_word(), odd);
    @(negedge clk_a);
    cs_a = 1; wr_a = 1; en_a = 1; data_a = exp;
    cs_b = 1; rd_b = 1; en_b = 1;
    @(negedge clk_a);
    en_a = 0; en_b = 0;
    chk(data_b === w, "R11 same-edge read", data_b, w);
    settle_a();
    chk(empty === 1'b0 && full === 1'b0, "R11 same-edge count", {34'd0, empty, full}, '0);
    pop(0, 0, got);
    chk(got === exp, "R11 same-edge write", got, exp);

    sim = 0; rd_pend = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_a);
      if (rd_pend) begin
        exp = q.pop_front();
        if (data_b !== exp) chk(1'b0, "R1 random", data_b, exp);
      end
      wv = 1'($urandom() % 2);
      rv = 1'($urandom() % 3 != 0);
      w = make_par(rnd_word(), odd);
      wacc = wv && !full;
      rd_pend = rv && !empty;
      if (wacc && rd_pend) sim++;
      cs_a = 1; wr_a = 1; en_a = wv; mb_a = 0; data_a = w;
      cs_b = 1; rd_b = 1; en_b = rv; mb_b = 0;
      if (wacc) q.push_back(w);
    end
    @(negedge clk_a);
    en_a = 0; en_b = 0;
    if (rd_pend) begin
      exp = q.pop_front();
      chk(data_b === exp, "R1 random tail", data_b, exp);
    end
    chk(sim > 0, "R11 collisions seen", 36'(sim), 36'd1);
    settle_b();
    while (!empty) begin
      pop(0, 0, got);
      exp = q.pop_front();
      chk(got === exp, "R1 drain", got, exp);
    end
    chk(q.size() == 0, "R1 nothing lost", 36'(q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule